// File: doc/BRIEF.md
# Multiplexed Four-Digit Decimal Counter Display

This block holds a binary event count between 0 and 9999 and presents it on four time-multiplexed seven-segment digits. A slow periodic tick, derived from the system clock, moves the count forward by one while the run enable input is high. A separate, faster scan tick steps a one-hot digit select around the four positions. For the selected position the block drives that digit's BCD value and, if enabled, a seven-segment pattern.

The binary count is split into decimal digits by a small sequencer. It divides by ten three times using a shift-and-subtract loop. The three remainders are the units, tens and hundreds digits, and the last quotient is the thousands digit. A conversion starts when the scan enters the last digit. Its result is copied into the display register only when the scan wraps back to the units digit. Every full scan therefore shows a single count value.

Both tick periods are parameters in clock cycles. CYC_SCAN defaults to 6 ms and CYC_COUNT to 200 ms at 100 MHz. CYC_COUNT must be even and at least 4. CYC_SCAN must be larger than 50 so that a conversion ends inside one digit period.

Top module: `scan_counter_display`

## Requirements
- R1: The count is a 16-bit binary value that stays within 0 to 9999. A tick taken at 9999 moves it to 0.
- R2: The count changes only on clock edges where run_en is high. While run_en is low, the displayed value stays fixed.
- R3: The slow tick comes from a flag that toggles every CYC_COUNT/2 cycles. The count advances on each rising edge of that flag. So holding run_en high for exactly N*CYC_COUNT clock edges raises the count by exactly N.
- R4: The displayed digits come from three successive divisions by ten. The remainders give units, tens and hundreds, and the final quotient gives thousands. Each digit is a BCD value from 0 to 9.
- R5: Exactly one bit of digit_sel is high at all times after reset. Bit 0 selects units, bit 1 tens, bit 2 hundreds and bit 3 thousands, and the select rotates 0, 1, 2, 3, 0.
- R6: Each select stays active for exactly CYC_SCAN clock cycles.
- R7: digit_code[5:2] carries the BCD value of the selected digit, and digit_code[1:0] is always 0.
- R8: Synchronous active-low reset clears the count and the shown digits and selects the units digit. Right after reset, digit_sel is 4'b0001, digit_code is 0 and seg is 7'h3F.
- R9: A conversion begins when the scan enters the thousands digit and finishes before the scan wraps. All four digits shown in one scan, from units through thousands, belong to the same count value.
- R10: seg[0] to seg[6] drive segments a to g, active high. The patterns for 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F in hex, and BCD codes 10 to 15 give all segments off. With SEG_EN set to 0, seg is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Lets the slow tick advance the count |
| digit_sel | output | 4 | One-hot digit select, bit 0 for units |
| digit_code | output | 6 | BCD of selected digit in bits 5:2, bits 1:0 zero |
| seg | output | 7 | Segments a (bit 0) to g (bit 6), active high |

## Verification
A count advance can land in the same cycle in which the converter captures its operand. It can also land in the same cycle in which a finished result is copied into the display at a scan wrap. The bench provokes this by holding run_en high for windows of random length while the scan keeps rotating. The slow tick period is set to 4 cycles, so the count changes many times within every scan. A scan read during counting is judged by two tests. Its four digits must form a value within the range the count could have held during that window. Every digit must stay constant over its whole select period. Each running window is closed on a whole number of slow-tick periods, and the count is then read again after a freeze. That read must match the exact total of ticks applied.

// File: rtl/dcd_pkg.sv
// Shared types and the segment encoding for the multiplexed counter display.
// Assumes a four-digit display and common-cathode, active-high segments.
package dcd_pkg;

    localparam int DIGITS   = 4;
    localparam int COUNT_W  = 16;
    localparam int COUNT_MAX = 9999;

    typedef logic [3:0] bcd_t;

    // Maps a BCD code onto segments a..g (bit 0 = a); codes 10..15 are blank.
    function automatic logic [6:0] seg7_of(input bcd_t code);
        logic [6:0] pat;
        case (code)
            4'd0:    pat = 7'h3F;
            4'd1:    pat = 7'h06;
            4'd2:    pat = 7'h5B;
            4'd3:    pat = 7'h4F;
            4'd4:    pat = 7'h66;
            4'd5:    pat = 7'h6D;
            4'd6:    pat = 7'h7D;
            4'd7:    pat = 7'h07;
            4'd8:    pat = 7'h7F;
            4'd9:    pat = 7'h6F;
            default: pat = 7'h00;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/dcd_period_timer.sv
// Free-running period timer: emits a one-cycle pulse every PERIOD cycles.
// Assumes PERIOD >= 2. Counts from reset release, independent of any enable.
module dcd_period_timer #(
    parameter int PERIOD = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    logic [W-1:0] cnt;

    // Wrapping cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

endmodule

// File: rtl/dcd_bin_counter.sv
// Binary 0..MAX counter advanced on the rising edge of a slow flag while the
// run enable is high. Assumes the flag holds for at least one cycle per level.
module dcd_bin_counter #(
    parameter int W   = 16,
    parameter int MAX = 9999
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         slow_flag,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = W'(MAX);

    logic flag_q;

    // Edge history of the slow flag and the count itself.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            count  <= '0;
        end else begin
            flag_q <= slow_flag;
            if (run_en && slow_flag && !flag_q)
                count <= (count == TOP) ? '0 : count + 1'b1;
        end
    end

    assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= TOP);

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |->
            ((count == $past(count) + 1'b1) || ($past(count) == TOP && count == '0)));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_en) |-> (count == $past(count)));

endmodule

// File: rtl/dcd_digit_splitter.sv
// Splits a binary value into four BCD digits by three restoring
// shift-and-subtract divisions by ten (W cycles each). Assumes the value is
// at most 9999 so the final quotient fits one digit. done pulses once.
module dcd_digit_splitter
    import dcd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [W-1:0]          value,
    output logic [DIGITS-1:0][3:0] dig,
    output logic                  done,
    output logic                  busy
);
    localparam int BW = $clog2(W);
    localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);
    localparam int SW = $clog2(DIGITS);
    localparam logic [SW-1:0] LAST_STAGE = SW'(DIGITS - 2);
    localparam int BOUND = (DIGITS - 1) * W + 1;

    typedef enum logic {SP_IDLE, SP_RUN} sp_state_t;

    sp_state_t     state;
    logic [W-1:0]  quo;
    logic [3:0]    rem;
    logic [BW-1:0] bitn;
    logic [SW-1:0] stage;

    logic [4:0]    trial;
    logic          ge;
    logic [3:0]    rem_n;
    logic [W-1:0]  quo_n;

    // One restoring division step: bring down a bit, subtract ten if it fits.
    always_comb begin
        trial = {rem, quo[W-1]};
        ge    = (trial >= 5'd10);
        rem_n = ge ? 4'(trial - 5'd10) : trial[3:0];
        quo_n = {quo[W-2:0], ge};
    end

    // Sequencer: load on start, step every cycle, store digits per stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SP_IDLE;
            quo   <= '0;
            rem   <= '0;
            bitn  <= '0;
            stage <= '0;
            dig   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SP_IDLE: begin
                    if (start) begin
                        state <= SP_RUN;
                        quo   <= value;
                        rem   <= '0;
                        bitn  <= '0;
                        stage <= '0;
                    end
                end
                SP_RUN: begin
                    if (bitn == LAST_BIT) begin
                        dig[stage] <= rem_n;
                        quo        <= quo_n;
                        rem        <= '0;
                        bitn       <= '0;
                        if (stage == LAST_STAGE) begin
                            dig[DIGITS-1] <= quo_n[3:0];
                            state         <= SP_IDLE;
                            done          <= 1'b1;
                        end else begin
                            stage <= stage + 1'b1;
                        end
                    end else begin
                        quo  <= quo_n;
                        rem  <= rem_n;
                        bitn <= bitn + 1'b1;
                    end
                end
                default: state <= SP_IDLE;
            endcase
        end
    end

    assign busy = (state == SP_RUN);

    // Checker counter: cycles spent in one conversion.
    logic [$clog2(BOUND+2)-1:0] run_len;
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) run_len <= '0;
        else                 run_len <= run_len + 1'b1;
    end

    assert_conv_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= ($clog2(BOUND+2))'(BOUND));

    assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    assert_digits_bcd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dig[0] <= 4'd9 && dig[1] <= 4'd9 && dig[2] <= 4'd9 && dig[3] <= 4'd9));

endmodule

// File: rtl/dcd_digit_scan.sv
// Digit scanner: rotates a one-hot select on each scan tick, asks for a new
// conversion on entering the last digit and latches the result on wrap, so a
// full scan never mixes two count values. Assumes conversions end in one period.
module dcd_digit_scan
    import dcd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scan_tick,
    input  logic [DIGITS-1:0][3:0] next_dig,
    output logic [DIGITS-1:0]      digit_sel,
    output logic [3:0]             bcd,
    output logic                   conv_start,
    output logic                   wrap
);
    localparam int PW = $clog2(DIGITS);
    localparam logic [PW-1:0] LAST_POS = PW'(DIGITS - 1);

    logic [PW-1:0]           pos;
    logic [DIGITS-1:0][3:0]  disp;

    // Scan position advance.
    always_ff @(posedge clk) begin
        if (!rst_n)         pos <= '0;
        else if (scan_tick) pos <= pos + 1'b1;
    end

    // Display snapshot, replaced only at the wrap to the first digit.
    always_ff @(posedge clk) begin
        if (!rst_n)    disp <= '0;
        else if (wrap) disp <= next_dig;
    end

    assign conv_start = scan_tick && (pos == LAST_POS - 1'b1);
    assign wrap       = scan_tick && (pos == LAST_POS);
    assign digit_sel  = DIGITS'(1) << pos;
    assign bcd        = disp[pos];

    assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(digit_sel) == 1);

    assert_sel_rotate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_sel != $past(digit_sel)) |->
            (digit_sel == {$past(digit_sel[DIGITS-2:0]), $past(digit_sel[DIGITS-1])}));

    assert_shown_bcd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bcd <= 4'd9);

endmodule

// File: rtl/scan_counter_display.sv
// Top: 0..9999 counter on a slow tick, shown on four multiplexed digits
// scanned by a fast tick. Assumes CYC_COUNT even and >= 4, CYC_SCAN > 50.
module scan_counter_display
    import dcd_pkg::*;
#(
    parameter int CYC_SCAN  = 600_000,
    parameter int CYC_COUNT = 20_000_000,
    parameter bit SEG_EN    = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    output logic [3:0] digit_sel,
    output logic [5:0] digit_code,
    output logic [6:0] seg
);
    localparam int HALF_COUNT = CYC_COUNT / 2;

    logic                   scan_tick;
    logic                   half_tick;
    logic                   slow_flag;
    logic [COUNT_W-1:0]     count;
    logic [DIGITS-1:0][3:0] conv_dig;
    logic                   conv_done;
    logic                   conv_busy;
    logic                   conv_start;
    logic                   wrap;
    logic [3:0]             bcd;

    dcd_period_timer #(.PERIOD(CYC_SCAN)) scan_tmr_i (
        .clk(clk), .rst_n(rst_n), .tick(scan_tick));

    dcd_period_timer #(.PERIOD(HALF_COUNT)) slow_tmr_i (
        .clk(clk), .rst_n(rst_n), .tick(half_tick));

    // Slow flag toggles every half period, giving one rising edge per period.
    always_ff @(posedge clk) begin
        if (!rst_n)         slow_flag <= 1'b0;
        else if (half_tick) slow_flag <= !slow_flag;
    end

    dcd_bin_counter #(.W(COUNT_W), .MAX(COUNT_MAX)) cnt_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .slow_flag(slow_flag), .count(count));

    dcd_digit_splitter #(.W(COUNT_W)) split_i (
        .clk(clk), .rst_n(rst_n), .start(conv_start), .value(count),
        .dig(conv_dig), .done(conv_done), .busy(conv_busy));

    dcd_digit_scan scan_i (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .next_dig(conv_dig),
        .digit_sel(digit_sel), .bcd(bcd), .conv_start(conv_start), .wrap(wrap));

    assign digit_code = {bcd, 2'b00};

    // Optional segment encoder.
    generate
        if (SEG_EN) begin : g_seg
            assign seg = seg7_of(bcd);
        end else begin : g_noseg
            assign seg = '0;
        end
    endgenerate

    assert_snapshot_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> !conv_busy);

    assert_done_before_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> !wrap);

endmodule

// File: tb/scan_counter_display_tb_top.sv
// Bench: directed wrap and reset cases plus seeded random run windows.
module scan_counter_display_tb_top;

    localparam int CYC_SCAN  = 64;
    localparam int CYC_COUNT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [3:0] digit_sel;
    logic [5:0] digit_code;
    logic [6:0] seg;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int exp_cnt  = 0;
    bit finished = 1'b0;

    scan_counter_display #(.CYC_SCAN(CYC_SCAN), .CYC_COUNT(CYC_COUNT), .SEG_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .digit_sel(digit_sel), .digit_code(digit_code), .seg(seg));

    always #5 clk = !clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [6:0] ref_seg(input int d);
        case (d)
            0: return 7'b0111111;
            1: return 7'b0000110;
            2: return 7'b1011011;
            3: return 7'b1001111;
            4: return 7'b1100110;
            5: return 7'b1101101;
            6: return 7'b1111101;
            7: return 7'b0000111;
            8: return 7'b1111111;
            9: return 7'b1101111;
            default: return 7'b0000000;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Waits for a scan wrap and reads one full scan; returns the shown value.
    task automatic read_scan(output int v);
        logic [3:0] prev;
        int d[4];
        int bad_sel = 0, bad_low = 0, bad_seg = 0, bad_const = 0, bad_bcd = 0;
        int a_sel = 0, e_sel = 0, a_seg = 0, e_seg = 0, a_c = 0, e_c = 0;
        prev = digit_sel;
        @(negedge clk);
        while (!(digit_sel == 4'b0001 && prev == 4'b1000)) begin
            prev = digit_sel;
            @(negedge clk);
        end
        for (int i = 0; i < 4 * CYC_SCAN; i++) begin
            int k;
            k = i / CYC_SCAN;
            if (digit_sel != 4'(1 << k)) begin
                if (bad_sel == 0) begin a_sel = digit_sel; e_sel = 1 << k; end
                bad_sel++;
            end
            if (digit_code[1:0] != 2'b00) bad_low++;
            if (i % CYC_SCAN == 0) d[k] = digit_code[5:2];
            else if (int'(digit_code[5:2]) != d[k]) begin
                if (bad_const == 0) begin a_c = digit_code[5:2]; e_c = d[k]; end
                bad_const++;
            end
            if (digit_code[5:2] > 4'd9) bad_bcd++;
            if (seg != ref_seg(digit_code[5:2])) begin
                if (bad_seg == 0) begin a_seg = seg; e_seg = ref_seg(digit_code[5:2]); end
                bad_seg++;
            end
            if (i < 4 * CYC_SCAN - 1) @(negedge clk);
        end
        check(bad_sel == 0, "R5/R6 select rotation and dwell", a_sel, e_sel);
        check(bad_low == 0, "R7 low code bits zero", bad_low, 0);
        check(bad_const == 0, "R9 digit stable through scan", a_c, e_c);
        check(bad_bcd == 0, "R4 digits in 0..9", bad_bcd, 0);
        check(bad_seg == 0, "R10 segment pattern", a_seg, e_seg);
        v = d[3] * 1000 + d[2] * 100 + d[1] * 10 + d[0];
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        run_en = 1'b1;
        repeat (n * CYC_COUNT) @(posedge clk);
        @(negedge clk);
        run_en = 1'b0;
        exp_cnt = (exp_cnt + n) % 10000;
    endtask

    task automatic frozen_read(input string req);
        int v;
        repeat (8 * CYC_SCAN) @(negedge clk);
        read_scan(v);
        check(v == exp_cnt, req, v, exp_cnt);
    endtask

    // Counting while scanning: any shown value must lie inside the window.
    task automatic running_read();
        int c0, v, span, off;
        @(negedge clk);
        run_en = 1'b1;
        c0 = cyc;
        repeat (2 * 4 * CYC_SCAN + int'($urandom_range(0, 40))) @(negedge clk);
        read_scan(v);
        span = (cyc - c0) / CYC_COUNT + 1;
        off = (v - exp_cnt + 10000) % 10000;
        check(off <= span, "R9 running scan value within window", off, span);
        while ((cyc - c0) % CYC_COUNT != 0) @(negedge clk);
        run_en = 1'b0;
        exp_cnt = (exp_cnt + (cyc - c0) / CYC_COUNT) % 10000;
        frozen_read("R3 exact tick total after running window");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(digit_sel == 4'b0001, "R8 reset select", digit_sel, 1);
        check(digit_code == 6'd0, "R8 reset code", digit_code, 0);
        check(seg == 7'h3F, "R8 reset segments", seg, 'h3F);

        // R2: no advance while run_en is low.
        frozen_read("R2 hold at zero with run_en low");

        // R1/R3: run to the top, wrap, continue.
        run_ticks(9999);
        frozen_read("R1 count reaches 9999");
        run_ticks(1);
        frozen_read("R1 wrap 9999 to 0");
        run_ticks(2);
        frozen_read("R3 two ticks after wrap");

        // R4/R3: random run windows.
        for (int it = 0; it < 10; it++) begin
            run_ticks(int'($urandom_range(1, 500)));
            frozen_read("R4 digits of random count");
        end

        // R9: count advancing during conversion and wrap.
        for (int it = 0; it < 3; it++) running_read();

        // R8: mid-run reset clears count.
        run_ticks(37);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_cnt = 0;
        @(negedge clk);
        check(digit_sel == 4'b0001, "R8 select after second reset", digit_sel, 1);
        frozen_read("R8 count cleared by reset");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule